// File: doc/BRIEF.md
# MDIO Management Controller

This block is a register-mapped station manager for the two-wire PHY management bus. A port's software issues a management transaction by writing a single command word that carries the target PHY address, the PHY register number, the direction and, for writes, sixteen data bits. The controller then produces the serial clock and shifts out a complete Clause 22 frame. For reads, it releases the data line at turnaround and shifts in the PHY's answer. Several network ports share the one controller, and they serialise their use of it by polling a busy flag.

The same command word is read back as a status word. It carries the transaction fields, the busy flag, the returned read data and a flag saying whether that data is trustworthy. A separate completion cause bit is raised when a frame ends, and a mask bit gates it onto a level interrupt line that other sources may share. Software acknowledges the completion by writing zero to the cause bit. The serial clock is the system clock divided by `2*DIV_HALF`.

Top module: `mdio_mgr`

## Requirements
- R1: After reset the command/status word at offset 0x00 reads all zero, the cause (0x7C) and mask (0x80) registers read zero, `irq` is low, `mdc` is low, `mdioOe` is low and `mdioOut` is high.
- R2: A write to offset 0x00 while bit 28 (busy) is clear sets busy on the following clock edge. Busy stays set for exactly `128*DIV_HALF` clock cycles, which is 64 serial bit times, and then clears.
- R3: A write to offset 0x00 while busy is set is ignored: the frame in flight and the fields read back at 0x00 are unchanged.
- R4: `mdc` spends `DIV_HALF` system cycles low and `DIV_HALF` high in each bit, and it is low whenever no frame is in flight.
- R5: The frame on `mdioOut` is 32 ones, start bits 01, opcode 10 for a read or 01 for a write, the 5-bit PHY address from command bits [20:16], and the 5-bit register number from bits [25:21], each sent MSB first. For a write, turnaround 10 and data bits [15:0] MSB first follow. `mdioOut` changes only while `mdc` is low.
- R6: For a write, `mdioOe` is high for all 64 bits. For a read (command bit 26 = 1), it is high for the first 46 bits and low from the turnaround to the end of the frame. The 16 read data bits are sampled on `mdc` rising edges, MSB first, and appear in bits [15:0] at 0x00.
- R7: Bit 27 (read-valid) is set at the end of a read only if the PHY drove 0 during the second turnaround bit. It is cleared when a new command is accepted and it is never set by a write.
- R8: Bit 4 of the cause register at 0x7C is set at the end of every frame. Writing 0 to bit 4 clears it and writing 1 to bit 4 leaves it unchanged. A frame end in the same cycle as a clearing write leaves the bit set.
- R9: Bit 4 of the mask register at 0x80 is read/write. `irq` is high exactly while both the cause bit and the mask bit are set.
- R10: Reading offset 0x00 returns data in [15:0], PHY address in [20:16], register number in [25:21], the read opcode in 26, read-valid in 27 and busy in 28, with bits [31:29] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte offset |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data, combinational on busAddr |
| mdc | output | 1 | Management serial clock |
| mdioOut | output | 1 | Management data driven to the pad |
| mdioOe | output | 1 | Output enable for the data pad |
| mdioIn | input | 1 | Management data from the pad |
| irq | output | 1 | Level completion interrupt |

## Verification
Two events can share a cycle. One is the frame end setting the completion cause while software writes zero to clear it. The bench schedules such a clearing write to land exactly on the edge where busy falls, and it requires the cause bit to read back as set. The other is a new command write arriving mid-frame. The bench injects an inverted command halfway through a transaction and requires the busy length, the serial frame and the read-back fields to match the original command.

// File: rtl/mdio_mgr_pkg.sv
package mdio_mgr_pkg;
  localparam int FRAME_LEN      = 64;
  localparam int ADDR_PHASE_LEN = 46;
  localparam int TA_LAST_IDX    = 47;
  localparam int BIT_IDX_W      = $clog2(FRAME_LEN);
  localparam int REG_ADDR_W     = 8;

  localparam logic [REG_ADDR_W-1:0] CMD_OFF   = 8'h00;
  localparam logic [REG_ADDR_W-1:0] CAUSE_OFF = 8'h7C;
  localparam logic [REG_ADDR_W-1:0] MASK_OFF  = 8'h80;

  localparam int DONE_BIT  = 4;
  localparam int PHY_LSB   = 16;
  localparam int REG_LSB   = 21;
  localparam int OP_BIT    = 26;
  localparam int VALID_BIT = 27;
  localparam int BUSY_BIT  = 28;

  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic done;
    logic addrPhase;
    logic taSample;
    logic dataSample;
  } strobe_t;
endpackage

// File: rtl/mdio_mgr_ctrl.sv
module mdio_mgr_ctrl
  import mdio_mgr_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdWr,
  output strobe_t stb,
  output logic    busy,
  output logic    mdc
);
  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [DIV_W-1:0]     divCnt;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic                 busyQ;
  logic                 mdcQ;
  logic                 tick;
  logic                 lastBit;
  logic                 riseEv;

  assign tick    = busyQ && (divCnt == DIV_W'(DIV_HALF - 1));
  assign lastBit = (bitIdx == BIT_IDX_W'(FRAME_LEN - 1));
  assign riseEv  = tick && !mdcQ;

  always_comb begin
    stb.load       = cmdWr && !busyQ;
    stb.rise       = riseEv;
    stb.fall       = tick && mdcQ;
    stb.done       = tick && mdcQ && lastBit;
    stb.addrPhase  = (bitIdx < BIT_IDX_W'(ADDR_PHASE_LEN));
    stb.taSample   = riseEv && (bitIdx == BIT_IDX_W'(TA_LAST_IDX));
    stb.dataSample = riseEv && (bitIdx > BIT_IDX_W'(TA_LAST_IDX));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      mdcQ   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (cmdWr && !busyQ) begin
      busyQ  <= 1'b1;
      mdcQ   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (busyQ) begin
      if (tick) begin
        divCnt <= '0;
        mdcQ   <= !mdcQ;
        if (mdcQ) begin
          if (lastBit) busyQ <= 1'b0;
          else         bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign busy = busyQ;
  assign mdc  = mdcQ;
endmodule

// File: rtl/mdio_mgr_dp.sv
module mdio_mgr_dp
  import mdio_mgr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic                  busy,
  input  logic                  busWrEn,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  input  logic                  mdioIn,
  output logic                  mdioOut,
  output logic                  mdioOe,
  output logic                  causeQ,
  output logic                  maskQ
);
  logic [FRAME_LEN-1:0] frameSh;
  logic [4:0]           phyQ;
  logic [4:0]           regQ;
  logic                 opRead;
  logic [15:0]          dataQ;
  logic                 taOk;
  logic                 rdValid;
  logic                 newRd;

  assign newRd = busWrData[OP_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameSh <= '1;
    end else if (stb.load) begin
      frameSh <= {32'hFFFF_FFFF, 2'b01, (newRd ? 2'b10 : 2'b01),
                  busWrData[PHY_LSB +: 5], busWrData[REG_LSB +: 5],
                  (newRd ? 2'b11 : 2'b10),
                  (newRd ? 16'hFFFF : busWrData[15:0])};
    end else if (stb.fall) begin
      frameSh <= {frameSh[FRAME_LEN-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyQ    <= '0;
      regQ    <= '0;
      opRead  <= 1'b0;
      dataQ   <= '0;
      taOk    <= 1'b0;
      rdValid <= 1'b0;
    end else if (stb.load) begin
      phyQ    <= busWrData[PHY_LSB +: 5];
      regQ    <= busWrData[REG_LSB +: 5];
      opRead  <= newRd;
      dataQ   <= busWrData[15:0];
      taOk    <= 1'b0;
      rdValid <= 1'b0;
    end else begin
      if (stb.taSample) taOk <= !mdioIn;
      if (stb.dataSample && opRead) dataQ <= {dataQ[14:0], mdioIn};
      if (stb.done) rdValid <= opRead && taOk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ <= 1'b0;
      maskQ  <= 1'b0;
    end else begin
      if (stb.done)
        causeQ <= 1'b1;
      else if (busWrEn && busAddr == CAUSE_OFF && !busWrData[DONE_BIT])
        causeQ <= 1'b0;
      if (busWrEn && busAddr == MASK_OFF)
        maskQ <= busWrData[DONE_BIT];
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      CMD_OFF: begin
        busRdData[15:0]            = dataQ;
        busRdData[PHY_LSB +: 5]    = phyQ;
        busRdData[REG_LSB +: 5]    = regQ;
        busRdData[OP_BIT]          = opRead;
        busRdData[VALID_BIT]       = rdValid;
        busRdData[BUSY_BIT]        = busy;
      end
      CAUSE_OFF: busRdData[DONE_BIT] = causeQ;
      MASK_OFF:  busRdData[DONE_BIT] = maskQ;
      default:   busRdData = '0;
    endcase
  end

  assign mdioOut = busy ? frameSh[FRAME_LEN-1] : 1'b1;
  assign mdioOe  = busy && (!opRead || stb.addrPhase);
endmodule

// File: rtl/mdio_mgr.sv
module mdio_mgr
  import mdio_mgr_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  output logic                  mdc,
  output logic                  mdioOut,
  output logic                  mdioOe,
  input  logic                  mdioIn,
  output logic                  irq
);
  strobe_t stb;
  logic    busy;
  logic    causeQ;
  logic    maskQ;
  logic    cmdWr;

  assign cmdWr = busWrEn && (busAddr == CMD_OFF);

  mdio_mgr_ctrl #(.DIV_HALF(DIV_HALF)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .cmdWr(cmdWr),
    .stb  (stb),
    .busy (busy),
    .mdc  (mdc)
  );

  mdio_mgr_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busy     (busy),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .mdioIn   (mdioIn),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe),
    .causeQ   (causeQ),
    .maskQ    (maskQ)
  );

  assign irq = causeQ && maskQ;
endmodule

// File: rtl/mdio_mgr_chk.sv
module mdio_mgr_chk
  import mdio_mgr_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWrEn,
  input logic [REG_ADDR_W-1:0] busAddr,
  input logic                  busy,
  input logic                  mdc,
  input logic                  mdioOut,
  input logic                  mdioOe,
  input logic                  causeQ,
  input logic                  maskQ,
  input logic                  irq
);
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == CMD_OFF && !busy) |=> busy);

  // R3
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == CMD_OFF && busy && !mdc) |=> busy);

  // R4
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  // R5
  mdio_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOut));

  // R6
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> busy);

  // R8
  cause_on_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> causeQ);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !maskQ |-> !irq);

  // R9
  irq_on_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && maskQ) |-> irq);
endmodule

bind mdio_mgr mdio_mgr_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busWrEn(busWrEn),
  .busAddr(busAddr),
  .busy   (busy),
  .mdc    (mdc),
  .mdioOut(mdioOut),
  .mdioOe (mdioOe),
  .causeQ (causeQ),
  .maskQ  (maskQ),
  .irq    (irq)
);

// File: tb/sim_mdio_mgr.sv
module sim_mdio_mgr;
  import mdio_mgr_pkg::*;

  localparam int HALF = 2;
  localparam int NCYC = 128 * HALF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWrData = 32'h0;
  logic [31:0] busRdData;
  logic        mdc, mdioOut, mdioOe, irq;
  logic        mdioIn = 1'b1;

  mdio_mgr #(.DIV_HALF(HALF)) u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn), .irq(irq)
  );

  always #5 clk = ~clk;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // PHY model and frame observer
  int          benchBit = 0;
  logic [63:0] obsOut = '0;
  logic [63:0] obsOe = '0;
  logic        taDrive = 1'b1;
  logic [15:0] phyWord = '0;

  always @(posedge mdc) begin
    if (benchBit < 64) begin
      obsOut[63-benchBit] = mdioOut;
      obsOe[63-benchBit]  = mdioOe;
    end
  end

  always @(negedge mdc) begin
    benchBit = benchBit + 1;
    if (benchBit == 47)                        mdioIn = taDrive ? 1'b0 : 1'b1;
    else if (benchBit >= 48 && benchBit < 64)  mdioIn = phyWord[63-benchBit];
    else                                       mdioIn = 1'b1;
  end

  // serial clock shape and data stability monitor
  int   runLen = 0;
  logic prevMdc = 1'b0;
  logic prevOut = 1'b1;
  int   mdcBad = 0;
  int   outBad = 0;
  bit   sawFall = 0;

  always @(negedge clk) begin
    if (mdc !== prevMdc) begin
      if (prevMdc && runLen != HALF) mdcBad++;
      if (!prevMdc && sawFall && runLen != HALF) mdcBad++;
      if (prevMdc) sawFall = 1;
      runLen = 1;
    end else begin
      runLen++;
    end
    if (mdioOut !== prevOut && prevMdc && mdc) outBad++;
    prevMdc = mdc;
    prevOut = mdioOut;
  end

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = CMD_OFF;
    #1;
  endtask

  task automatic readReg(logic [7:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  bit maskShadow = 0;

  task automatic runTxn(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] data,
                        bit taGood, logic [15:0] pw, int mode);
    logic [31:0] cmd, v, expRb;
    logic [63:0] expF, expOe;
    int cnt;
    cmd = {5'b0, rd, rg, phy, data};
    taDrive = taGood; phyWord = pw; benchBit = 0; sawFall = 0;
    obsOut = '0; obsOe = '0;
    busWrite(CMD_OFF, cmd);
    readReg(CMD_OFF, v);
    check("R2 busy after command", 64'(v[BUSY_BIT]), 64'd1);
    check("R7 valid cleared on accept", 64'(v[VALID_BIT]), 64'd0);
    cnt = 0;
    while (1) begin
      if (mode == 1 && cnt == NCYC / 2) begin
        busWrEn = 1'b1; busAddr = CMD_OFF; busWrData = ~cmd;
      end
      if (mode == 2 && cnt == NCYC - 1) begin
        busWrEn = 1'b1; busAddr = CAUSE_OFF; busWrData = 32'hFFFF_FFEF;
      end
      @(negedge clk);
      busWrEn = 1'b0; busAddr = CMD_OFF;
      #1;
      cnt++;
      if (!busRdData[BUSY_BIT] || cnt > NCYC + 10) break;
    end
    check(mode == 1 ? "R3 R2 busy length with ignored command" : "R2 busy length",
          64'(cnt), 64'(NCYC));
    expF = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, data};
    if (rd) check("R5 read frame header", 64'(obsOut[63:18]), 64'(expF[63:18]));
    else    check("R5 write frame", obsOut, expF);
    expOe = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    check("R6 output enable pattern", obsOe, expOe);
    expRb = {3'b000, 1'b0, rd && taGood, rd, rg, phy, (rd ? pw : data)};
    readReg(CMD_OFF, v);
    check(mode == 1 ? "R3 R10 fields after ignored command" : "R10 R7 R6 status word",
          64'(v), 64'(expRb));
    readReg(CAUSE_OFF, v);
    check(mode == 2 ? "R8 end wins over clear" : "R8 cause set at end", 64'(v), 64'h10);
    check("R9 irq follows mask", 64'(irq), 64'(maskShadow));
    busWrite(CAUSE_OFF, 32'h0000_0010);
    readReg(CAUSE_OFF, v);
    check("R8 write one keeps cause", 64'(v), 64'h10);
    busWrite(CAUSE_OFF, 32'hFFFF_FFEF);
    readReg(CAUSE_OFF, v);
    check("R8 write zero clears cause", 64'(v), 64'h0);
    check("R9 irq low after clear", 64'(irq), 64'd0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    readReg(CMD_OFF, v);   check("R1 status word reset", 64'(v), 64'h0);
    readReg(CAUSE_OFF, v); check("R1 cause reset", 64'(v), 64'h0);
    readReg(MASK_OFF, v);  check("R1 mask reset", 64'(v), 64'h0);
    check("R1 pins reset", {60'h0, irq, mdc, mdioOe, mdioOut}, 64'h1);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R4 mdc idle low", 64'(mdc), 64'd0);
    busWrite(MASK_OFF, 32'hFFFF_FFFF);
    maskShadow = 1;
    readReg(MASK_OFF, v);
    check("R9 mask readback", 64'(v), 64'h10);
    for (int i = 0; i < 32; i++) begin
      if (i == 16) begin
        busWrite(MASK_OFF, 32'h0);
        maskShadow = 0;
      end
      runTxn(i[0], 5'(i), 5'(i * 7 + 3), 16'(i * 16'h1357) ^ 16'hA5C3,
             (i % 5) != 3, 16'(16'hC0DE + i * 16'h0101),
             (i == 5) ? 1 : ((i == 10) ? 2 : 0));
    end
    check("R4 mdc half periods", 64'(mdcBad), 64'd0);
    check("R5 mdio changes only with mdc low", 64'(outBad), 64'd0);
    check("R4 mdc low after frames", 64'(mdc), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      nChk++;
      nFail++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule